// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block sits on the peripheral side of a processor bus. It raises an interrupt request at a configured priority level. It then watches the bus for the processor's acknowledge of that request. When the acknowledge is seen, it supplies a programmed 8-bit vector number on the data byte lane that suits the configured port width, and it returns the matching size acknowledge. If no vector is programmed, it ends the cycle with an autovector reply instead.

An acknowledge can be recognised in two ways. The first uses the bus decode: a CPU-space function code, the acknowledge space type in the upper address field, and the request level in the low address bits. The second uses a dedicated per-level acknowledge strobe. The reply is held while both bus strobes stay asserted. It is withdrawn, and the request is retired, on the first clock after the master lets go of either strobe.

All bus inputs are assumed synchronous to `clk`. The configuration inputs are assumed stable while a request is pending.

Top module: `iack_responder`

## Requirements
- R1: Out of reset every `irq_req_n` line is high. A `raise_i` pulse sampled at a clock edge drives `irq_req_n[cfg_level-1]` low after that edge. A configured level of 0 never drives any line low.
- R2: A bus-decoded acknowledge needs all of the following while `as_n` and `ds_n` are both low: `fc_i` equal to 4'b0111, `addr_i[19:16]` equal to 4'hF, and `addr_i[3:1]` equal to `cfg_level`. If any one of these differs, the block gives no response.
- R3: A strobe acknowledge needs `iack_n[cfg_level-1]` low while `as_n` and `ds_n` are both low. In that case `fc_i` and `addr_i` are ignored. A strobe for any other level gives no response.
- R4: The vector is driven on one byte lane, chosen by `cfg_port_w`. Code 2'b00 (8-bit port) uses `data_o[31:24]`. Code 2'b01 (16-bit port) uses `data_o[23:16]`. Code 2'b10 or 2'b11 (32-bit port) uses `data_o[7:0]`. All other bits are zero, and the value stays stable while it is driven.
- R5: The size acknowledge `size_ack_n` is 2'b10 for an 8-bit port, 2'b01 for a 16-bit port and 2'b00 for a 32-bit port. It appears, together with `data_oe` high, on the clock after the acknowledge is first sampled.
- R6: When `cfg_vec_valid` is low, the reply is `avec_n` low, with `size_ack_n` held at 2'b11 and `data_oe` low. A size acknowledge and an autovector are never given together.
- R7: The first clock edge that samples `as_n` or `ds_n` high ends the reply. After that edge, `size_ack_n` is 2'b11, `avec_n` is high, `data_oe` is low and `data_o` is zero. `data_oe` is only ever high after a cycle in which both strobes were low.
- R8: The pending request is cleared at the edge that ends the reply, so every `irq_req_n` line is high afterwards.
- R9: With no request pending, a matching acknowledge gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level | input | 3 | Request level, 1 to 7 (0 disables) |
| cfg_vector | input | 8 | Vector number to supply |
| cfg_vec_valid | input | 1 | 1: supply vector, 0: answer with autovector |
| cfg_port_w | input | 2 | Port width: 00 8-bit, 01 16-bit, 1x 32-bit |
| raise_i | input | 1 | Pulse that makes a request pending |
| irq_req_n | output | 7 | Active-low request, one line per level 1..7 |
| fc_i | input | 4 | Bus function code |
| addr_i | input | 32 | Bus address |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| iack_n | input | 7 | Per-level acknowledge strobes, active low |
| data_o | output | 32 | Data bus value (zero when not driven) |
| data_oe | output | 1 | Data bus drive enable |
| size_ack_n | output | 2 | Size acknowledge, active low |
| avec_n | output | 1 | Autovector reply, active low |

## Verification
The assertions watch a few rules on every cycle. They check that the data enable only follows a cycle with both strobes asserted, and that an autovector and a size acknowledge never appear together. They check that a size acknowledge always comes with driven data, that a driven vector holds steady, that a reply starts only with a request pending, and that the request line is released when the reply ends. Other behaviour can only be shown by the bench's scenarios: the lane and size code for each port width, each way a decoded cycle can fail to match, strobe-based recognition, and release on the loss of only one strobe.

// File: rtl/iack_resp_pkg.sv
// Package: shared types and constants of the acknowledge responder.
// Assumes a byte-wide vector and a 2-bit port width code.
package iack_resp_pkg;

    typedef enum logic [1:0] {
        PW_BYTE = 2'b00,
        PW_WORD = 2'b01,
        PW_LONG = 2'b10,
        PW_LONG2 = 2'b11
    } port_w_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } ack_st_e;

    localparam logic [3:0] FC_CPU_SPACE = 4'b0111;
    localparam logic [3:0] SPACE_IACK   = 4'hF;
    localparam logic [1:0] SACK_NONE    = 2'b11;

    // Active-low size acknowledge code for a port width.
    function automatic logic [1:0] size_code(input port_w_e w);
        case (w)
            PW_BYTE: return 2'b10;
            PW_WORD: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/iack_decode.sv
// Decoder: flags a bus cycle that acknowledges the configured level, either
// from function code, space field and level bits or from the level's strobe.
// Assumes inputs synchronous to the clock of the consumer; purely combinational.
module iack_decode
    import iack_resp_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 32,
    localparam int NLVL  = (1 << LVL_W) - 1
) (
    input  logic [3:0]        fc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NLVL-1:0]   iack_n,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic [LVL_W-1:0]  level,
    output logic              hit
);

    logic space_hit;
    logic lvl_hit;
    logic strobe_hit;
    logic unused_addr;

    assign space_hit   = (fc_i == FC_CPU_SPACE) && (addr_i[19:16] == SPACE_IACK);
    assign lvl_hit     = (addr_i[LVL_W:1] == level);
    assign unused_addr = ^{addr_i[ADDR_W-1:20], addr_i[15:LVL_W+1], addr_i[0]};

    // Strobe path: the strobe belonging to the configured level is low.
    always_comb begin
        strobe_hit = 1'b0;
        for (int i = 1; i <= NLVL; i++) begin
            if (level == LVL_W'(i) && !iack_n[i-1]) strobe_hit = 1'b1;
        end
    end

    assign hit = !as_n && !ds_n && (level != '0) &&
                 ((space_hit && lvl_hit) || strobe_hit);

endmodule

// File: rtl/iack_req_ctrl.sv
// Request control: holds the pending flag and fans it out to the
// active-low request line of the configured level. Raise wins over clear.
module iack_req_ctrl #(
    parameter int LVL_W = 3,
    localparam int NLVL = (1 << LVL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             raise_i,
    input  logic             done,
    output logic             pend,
    output logic [NLVL-1:0]  irq_req_n
);

    // Pending flag: set on raise (level nonzero), cleared when a reply ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (raise_i && level != '0) begin
            pend <= 1'b1;
        end else if (done) begin
            pend <= 1'b0;
        end
    end

    for (genvar g = 1; g <= NLVL; g++) begin : g_line
        assign irq_req_n[g-1] = !(pend && level == LVL_W'(g));
    end

endmodule

// File: rtl/iack_ack_fsm.sv
// Reply sequencer: enters the reply state on a matching cycle with a
// request pending, drives the registered size or autovector reply, and
// leaves on the first sampled negation of either strobe.
module iack_ack_fsm
    import iack_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       pend,
    input  logic       vec_valid,
    input  port_w_e    port_w,
    input  logic       as_n,
    input  logic       ds_n,
    output logic       load,
    output logic       done,
    output logic       oe_q,
    output logic [1:0] sack_n_q,
    output logic       avec_n_q
);

    ack_st_e state;
    logic    start;

    assign start = (state == ST_IDLE) && hit && pend;
    assign load  = start && vec_valid;
    assign done  = (state == ST_ACK) && (as_n || ds_n);

    // State and registered reply outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            oe_q     <= 1'b0;
            sack_n_q <= SACK_NONE;
            avec_n_q <= 1'b1;
        end else if (start) begin
            state    <= ST_ACK;
            oe_q     <= vec_valid;
            sack_n_q <= vec_valid ? size_code(port_w) : SACK_NONE;
            avec_n_q <= vec_valid;
        end else if (done) begin
            state    <= ST_IDLE;
            oe_q     <= 1'b0;
            sack_n_q <= SACK_NONE;
            avec_n_q <= 1'b1;
        end
    end

    p_oe_after_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> $past(!as_n && !ds_n));

    p_one_reply_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!avec_n_q && sack_n_q != SACK_NONE));

    p_size_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sack_n_q != SACK_NONE) |-> oe_q);

endmodule

// File: rtl/iack_vec_lane.sv
// Lane steering: places the vector on the least significant byte lane of
// the configured port and holds it until the reply ends.
module iack_vec_lane
    import iack_resp_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int BUS_W = 32,
    localparam int NLANE = BUS_W / VEC_W,
    localparam int LN_W  = $clog2(NLANE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] vector,
    input  port_w_e          port_w,
    input  logic             load,
    input  logic             clr,
    output logic [BUS_W-1:0] data_q
);

    logic [LN_W-1:0]  sel;
    logic [BUS_W-1:0] lane_val;

    // Lane index: top lane for a byte port, next for a word port, lane 0 otherwise.
    always_comb begin
        case (port_w)
            PW_BYTE: sel = LN_W'(NLANE - 1);
            PW_WORD: sel = LN_W'(NLANE - 2);
            default: sel = '0;
        endcase
    end

    for (genvar b = 0; b < NLANE; b++) begin : g_lane
        assign lane_val[b*VEC_W +: VEC_W] = (sel == LN_W'(b)) ? vector : '0;
    end

    // Data register: captured at reply start, zeroed at reply end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= lane_val;
        end else if (clr) begin
            data_q <= '0;
        end
    end

    p_vector_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr && data_q != '0) |=> $stable(data_q));

endmodule

// File: rtl/iack_responder.sv
// Top: interrupt acknowledge vector responder. Raises a request at the
// configured level, recognises the matching acknowledge and answers with
// a lane-steered vector and size acknowledge, or with autovector.
// Assumes bus inputs synchronous to clk and stable configuration.
module iack_responder
    import iack_resp_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int VEC_W  = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 32,
    localparam int NLVL  = (1 << LVL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic [VEC_W-1:0]  cfg_vector,
    input  logic              cfg_vec_valid,
    input  logic [1:0]        cfg_port_w,
    input  logic              raise_i,
    output logic [NLVL-1:0]   irq_req_n,
    input  logic [3:0]        fc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic [NLVL-1:0]   iack_n,
    output logic [BUS_W-1:0]  data_o,
    output logic              data_oe,
    output logic [1:0]        size_ack_n,
    output logic              avec_n
);

    logic    hit;
    logic    pend;
    logic    load;
    logic    done;
    logic    ack_act;
    port_w_e pw;

    assign pw      = port_w_e'(cfg_port_w);
    assign ack_act = (size_ack_n != SACK_NONE) || !avec_n;

    iack_decode #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_dec (
        .fc_i(fc_i), .addr_i(addr_i), .iack_n(iack_n), .as_n(as_n),
        .ds_n(ds_n), .level(cfg_level), .hit(hit)
    );

    iack_req_ctrl #(.LVL_W(LVL_W)) u_req (
        .clk(clk), .rst_n(rst_n), .level(cfg_level), .raise_i(raise_i),
        .done(done), .pend(pend), .irq_req_n(irq_req_n)
    );

    iack_ack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .pend(pend),
        .vec_valid(cfg_vec_valid), .port_w(pw), .as_n(as_n), .ds_n(ds_n),
        .load(load), .done(done), .oe_q(data_oe), .sack_n_q(size_ack_n),
        .avec_n_q(avec_n)
    );

    iack_vec_lane #(.VEC_W(VEC_W), .BUS_W(BUS_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .vector(cfg_vector), .port_w(pw),
        .load(load), .clr(done), .data_q(data_o)
    );

    p_reply_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_act) |-> $past(pend));

    p_req_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_act) && !$past(raise_i)) |-> (&irq_req_n));

endmodule

// File: tb/iack_responder_tb_top.sv
// Scoreboard bench: bus_cycle pushes the expected reply into a queue and a
// monitor pops and compares it when the reply appears.
module iack_responder_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] data;
        logic [1:0]  sack;
        logic        avec;
        logic        oe;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_level = 3'd0;
    logic [7:0]  cfg_vector = 8'h00;
    logic        cfg_vec_valid = 1'b1;
    logic [1:0]  cfg_port_w = 2'b00;
    logic        raise_i = 1'b0;
    logic [6:0]  irq_req_n;
    logic [3:0]  fc_i = 4'h0;
    logic [31:0] addr_i = 32'h0;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic [6:0]  iack_n = 7'h7F;
    logic [31:0] data_o;
    logic        data_oe;
    logic [1:0]  size_ack_n;
    logic        avec_n;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    iack_responder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
        .cfg_vec_valid(cfg_vec_valid), .cfg_port_w(cfg_port_w), .raise_i(raise_i),
        .irq_req_n(irq_req_n), .fc_i(fc_i), .addr_i(addr_i), .as_n(as_n),
        .ds_n(ds_n), .iack_n(iack_n), .data_o(data_o), .data_oe(data_oe),
        .size_ack_n(size_ack_n), .avec_n(avec_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] lane_of(input logic [1:0] w, input logic [7:0] v);
        case (w)
            2'b00:   return {v, 24'h0};
            2'b01:   return {8'h0, v, 16'h0};
            default: return {24'h0, v};
        endcase
    endfunction

    function automatic logic [1:0] sack_of(input logic [1:0] w);
        case (w)
            2'b00:   return 2'b10;
            2'b01:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [6:0] irq_of(input logic [2:0] lvl, input bit pend);
        if (pend && lvl != 3'd0) return ~(7'h01 << (lvl - 3'd1));
        return 7'h7F;
    endfunction

    // Monitor: compares the reply against the scoreboard when it first appears.
    logic ack_prev = 1'b0;
    always @(negedge clk) begin
        logic act;
        act = (size_ack_n != 2'b11) || !avec_n;
        if (rst_n && act && !ack_prev) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "unexpected reply", {62'h0, size_ack_n}, 64'h3);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(data_o == e.data, e.req, "vector lane", 64'(data_o), 64'(e.data));
                check(size_ack_n == e.sack, e.req, "size ack", 64'(size_ack_n), 64'(e.sack));
                check(avec_n == e.avec, e.req, "autovector", 64'(avec_n), 64'(e.avec));
                check(data_oe == e.oe, e.req, "data enable", 64'(data_oe), 64'(e.oe));
            end
        end
        ack_prev <= act;
    end

    task automatic raise_req();
        @(negedge clk) raise_i = 1'b1;
        @(negedge clk) raise_i = 1'b0;
    endtask

    // Driver: runs one bus cycle and queues the reply it should produce.
    task automatic bus_cycle(input logic [3:0] fc, input logic [3:0] sp,
                             input logic [2:0] alvl, input logic [6:0] strb_n,
                             input bit expect_rsp, input bit ds_only, input string req);
        @(negedge clk);
        fc_i   = fc;
        addr_i = {12'hFFF, sp, 12'hFFF, alvl, 1'b1};
        iack_n = strb_n;
        if (expect_rsp) begin
            exp_t e;
            e.oe   = cfg_vec_valid;
            e.data = cfg_vec_valid ? lane_of(cfg_port_w, cfg_vector) : 32'h0;
            e.sack = cfg_vec_valid ? sack_of(cfg_port_w) : 2'b11;
            e.avec = cfg_vec_valid;
            e.req  = req;
            sb_q.push_back(e);
        end
        as_n = 1'b0;
        ds_n = 1'b0;
        repeat (3) @(negedge clk);
        if (expect_rsp) begin
            check(data_oe == cfg_vec_valid, req, "reply held", 64'(data_oe), 64'(cfg_vec_valid));
        end else begin
            check(size_ack_n == 2'b11 && avec_n && !data_oe, req, "no response",
                  {61'h0, size_ack_n, avec_n}, 64'h7);
        end
        if (ds_only) begin
            ds_n = 1'b1;
        end else begin
            as_n = 1'b1;
            ds_n = 1'b1;
        end
        @(negedge clk);
        check(size_ack_n == 2'b11 && avec_n && !data_oe && data_o == 32'h0, "R7",
              "released", {28'h0, data_o, size_ack_n, avec_n, data_oe}, {28'h0, 32'h0, 4'b1110});
        as_n   = 1'b1;
        ds_n   = 1'b1;
        iack_n = 7'h7F;
        fc_i   = 4'h0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq_req_n == 7'h7F && size_ack_n == 2'b11 && avec_n && !data_oe,
              "R1", "reset", {55'h0, irq_req_n, size_ack_n}, {55'h0, 7'h7F, 2'b11});

        // R1 raise at level 5, 8-bit port
        cfg_level = 3'd5; cfg_vector = 8'hA5; cfg_vec_valid = 1'b1; cfg_port_w = 2'b00;
        raise_req();
        check(irq_req_n == irq_of(3'd5, 1'b1), "R1", "request line", 64'(irq_req_n), 64'(irq_of(3'd5, 1'b1)));

        // R2 mismatches: level bits, function code, space field
        bus_cycle(4'b0111, 4'hF, 3'd3, 7'h7F, 1'b0, 1'b0, "R2");
        bus_cycle(4'b0110, 4'hF, 3'd5, 7'h7F, 1'b0, 1'b0, "R2");
        bus_cycle(4'b0111, 4'hE, 3'd5, 7'h7F, 1'b0, 1'b0, "R2");
        check(irq_req_n == irq_of(3'd5, 1'b1), "R2", "still pending", 64'(irq_req_n), 64'(irq_of(3'd5, 1'b1)));

        // R2 R4 R5 matching decoded cycle, 8-bit lane
        bus_cycle(4'b0111, 4'hF, 3'd5, 7'h7F, 1'b1, 1'b0, "R4");
        check(irq_req_n == 7'h7F, "R8", "request cleared", 64'(irq_req_n), 64'h7F);

        // R9 no pending request
        bus_cycle(4'b0111, 4'hF, 3'd5, 7'h7F, 1'b0, 1'b0, "R9");

        // R3 strobe path, 16-bit port; wrong-level strobe first
        cfg_vector = 8'h3C; cfg_port_w = 2'b01;
        raise_req();
        bus_cycle(4'b0001, 4'h0, 3'd0, 7'b1111011, 1'b0, 1'b0, "R3");
        bus_cycle(4'b0001, 4'h0, 3'd0, 7'b1101111, 1'b1, 1'b0, "R3");
        check(irq_req_n == 7'h7F, "R8", "request cleared", 64'(irq_req_n), 64'h7F);

        // R5 32-bit port, release on data strobe only (R7)
        cfg_vector = 8'h81; cfg_port_w = 2'b10;
        raise_req();
        bus_cycle(4'b0111, 4'hF, 3'd5, 7'h7F, 1'b1, 1'b1, "R5");

        // R4 alternate long code
        cfg_vector = 8'h42; cfg_port_w = 2'b11;
        raise_req();
        bus_cycle(4'b0111, 4'hF, 3'd5, 7'h7F, 1'b1, 1'b0, "R4");

        // R6 autovector
        cfg_vec_valid = 1'b0;
        raise_req();
        bus_cycle(4'b0111, 4'hF, 3'd5, 7'h7F, 1'b1, 1'b0, "R6");
        check(irq_req_n == 7'h7F, "R8", "cleared after autovector", 64'(irq_req_n), 64'h7F);

        // R1 level 0 never raises
        cfg_vec_valid = 1'b1; cfg_level = 3'd0;
        raise_req();
        check(irq_req_n == 7'h7F, "R1", "level zero", 64'(irq_req_n), 64'h7F);

        // R2 top level, 8-bit port
        cfg_level = 3'd7; cfg_vector = 8'hFF; cfg_port_w = 2'b00;
        raise_req();
        check(irq_req_n == irq_of(3'd7, 1'b1), "R1", "level 7 line", 64'(irq_req_n), 64'(irq_of(3'd7, 1'b1)));
        bus_cycle(4'b0111, 4'hF, 3'd7, 7'h7F, 1'b1, 1'b0, "R2");

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R5", "all replies seen", 64'(sb_q.size()), 64'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule